// File: doc/BRIEF.md
# Bus Page Address Map

The block translates an 18-bit peripheral bus address into a 22-bit physical memory address through a bank of page map registers. The bus address splits into two fields. Bits 17..13 give a page number, which picks one of 32 map entries. Bits 12..0 give an offset, which is added to the selected entry. The result wraps modulo 2^22.

Page 31, the highest bus page, never uses its map entry. It always lands in the top 8 KB of physical space, at base 0x3FE000 plus the offset. A map-enable input chooses the mode for each translation:
- With the map on, the address is translated as described above.
- With the map off, the bus address is passed through unmapped, zero-extended to 22 bits.

A register port gives software access to each 22-bit entry as two 16-bit words:
- The low word holds entry bits 15..0.
- The high word holds entry bits 21..16, right-aligned.

The port takes word and byte writes. Bit 0 of every entry is held at zero. A translation is requested with a one-cycle strobe. The result appears one clock later, together with a one-cycle valid pulse. The result register then keeps that address until the next request.

Top module: `bus_page_map`

## Requirements
- R1: After reset, every entry reads back as zero in both words, `xl_valid` is 0 and `xl_paddr` is 0.
- R2: Entry bit 0 is always zero. A write that sets bit 0 of the low word reads back with bit 0 cleared.
- R3: `reg_rdata` is combinational from `reg_addr`, and `reg_addr[0]` is ignored for reads. When `reg_addr[1]`=0, it returns entry bits 15..0. When `reg_addr[1]`=1, it returns entry bits 21..16 in bits 5..0, with bits 15..6 at zero.
- R4: A word write (`reg_byte`=0) replaces only the half selected by `reg_addr[1]`. Half 0 is entry bits 15..0. Half 1 is entry bits 21..16, taken from `reg_wdata[5:0]`; the other data bits are dropped.
- R5: A byte write (`reg_byte`=1) places `reg_wdata[7:0]` in byte lane `reg_addr[1:0]` of the entry, and leaves the other lanes unchanged:
  - lane 0 is bits 7..0;
  - lane 1 is bits 15..8;
  - lane 2 is bits 21..16, from data bits 5..0;
  - lane 3 lies above bit 21 and has no effect.
- R6: The entry index is `reg_addr[6:2]`. A write changes only the entry it indexes.
- R7: With `map_enable`=1 and page below 31, a request sets `xl_paddr` to (entry[`xl_addr[17:13]`] + `xl_addr[12:0]`) mod 2^22 one clock after `xl_req`.
- R8: With `map_enable`=1 and page 31, the result is 0x3FE000 + offset, whatever entry 31 holds.
- R9: With `map_enable`=0, the result is `xl_addr` zero-extended to 22 bits.
- R10: `xl_valid` is high for exactly the cycle after each `xl_req`. Without a request, `xl_paddr` keeps the last translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_byte | input | 1 | 1 = byte write, 0 = word write |
| reg_addr | input | 7 | Entry index in [6:2], byte lane / half in [1:0] |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| map_enable | input | 1 | 1 = translate through map, 0 = pass bus address through |
| xl_req | input | 1 | Translation strobe |
| xl_addr | input | 18 | Bus address to translate |
| xl_valid | output | 1 | Pulses the cycle after a request |
| xl_paddr | output | 22 | Last translated physical address |

## Verification
The bench mixes seeded random writes, reads and translations with directed cases, and compares each one against a reference model. The directed cases target the faults most likely here:
- Lane 3 byte writes and the high-word upper data bits. A design that kept these bits would grow the entry past 22 bits and corrupt high-word readback.
- Odd data into the low word. A missing bit-0 clear shows up as odd readback and odd physical addresses.
- Page 31 with a nonzero entry 31. A design that forgot the I/O bypass would return the entry's value instead of the fixed base.
- An entry near the top of physical space plus a large offset. This exposes any width error in the wrap.
- Idle cycles after a request. These catch a result register that does not hold or a valid that stays high.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  typedef enum logic {
    WR_WORD = 1'b0,
    WR_BYTE = 1'b1
  } wr_size_e;

  localparam int unsigned LANE_BITS = 2;
  localparam int unsigned STAGE_W   = 32;
endpackage

// File: rtl/pgmap_wrmerge.sv
module pgmap_wrmerge
  import pgmap_pkg::*;
#(
  parameter int unsigned PA_W = 22
) (
  input  logic [PA_W-1:0]      cur,
  input  logic [15:0]          wdata,
  input  wr_size_e             size,
  input  logic [LANE_BITS-1:0] lane,
  output logic [PA_W-1:0]      nxt
);
  logic [STAGE_W-1:0] wide;
  logic [STAGE_W-1:0] lane_mask;
  logic [STAGE_W-1:0] lane_data;
  logic [STAGE_W-1:0] merged;

  always_comb begin
    wide = STAGE_W'(cur);
    if (size == WR_BYTE) begin
      lane_mask = STAGE_W'(32'h0000_00FF) << {lane, 3'b000};
      lane_data = STAGE_W'({24'd0, wdata[7:0]}) << {lane, 3'b000};
    end else begin
      lane_mask = STAGE_W'(32'h0000_FFFF) << {lane[1], 4'b0000};
      lane_data = STAGE_W'({16'd0, wdata}) << {lane[1], 4'b0000};
    end
    merged = (wide & ~lane_mask) | lane_data;
    nxt    = merged[PA_W-1:0] & ~PA_W'(1);
  end
endmodule

// File: rtl/pgmap_bank.sv
module pgmap_bank
  import pgmap_pkg::*;
#(
  parameter int unsigned PA_W  = 22,
  parameter int unsigned IDX_W = 5,
  localparam int unsigned N_ENT = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  wr_size_e             wr_size,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [LANE_BITS-1:0] wr_lane,
  input  logic [15:0]          wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [PA_W-1:0]      rd_entry,
  input  logic [IDX_W-1:0]     xl_idx,
  output logic [PA_W-1:0]      xl_entry
);
  logic [PA_W-1:0] ent_q [N_ENT];
  logic [PA_W-1:0] ent_d [N_ENT];
  logic [PA_W-1:0] merged;

  pgmap_wrmerge #(.PA_W(PA_W)) u_merge (
    .cur   (ent_q[wr_idx]),
    .wdata (wr_data),
    .size  (wr_size),
    .lane  (wr_lane),
    .nxt   (merged)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_comb begin
      ent_d[g] = ent_q[g];
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        ent_d[g] = merged;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else begin
        ent_q[g] <= ent_d[g];
      end
    end
  end

  assign rd_entry = ent_q[rd_idx];
  assign xl_entry = ent_q[xl_idx];
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate #(
  parameter int unsigned BA_W  = 18,
  parameter int unsigned PA_W  = 22,
  parameter int unsigned OFF_W = 13,
  localparam int unsigned PG_W = BA_W - OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            map_on,
  input  logic [BA_W-1:0] ba,
  input  logic [PA_W-1:0] entry,
  output logic            valid,
  output logic [PA_W-1:0] paddr
);
  localparam logic [PA_W-1:0] IO_BASE = {{(PA_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic [PG_W-1:0]  page;
  logic [OFF_W-1:0] off;
  logic [PA_W-1:0]  result;
  logic             valid_d;
  logic [PA_W-1:0]  paddr_d;

  always_comb begin
    page = ba[BA_W-1:OFF_W];
    off  = ba[OFF_W-1:0];
    if (!map_on) begin
      result = PA_W'(ba);
    end else if (page == '1) begin
      result = IO_BASE + PA_W'(off);
    end else begin
      result = entry + PA_W'(off);
    end
    valid_d = req;
    paddr_d = req ? result : paddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      paddr <= '0;
    end else begin
      valid <= valid_d;
      paddr <= paddr_d;
    end
  end
endmodule

// File: rtl/bus_page_map.sv
module bus_page_map
  import pgmap_pkg::*;
#(
  parameter int unsigned BA_W  = 18,
  parameter int unsigned PA_W  = 22,
  parameter int unsigned OFF_W = 13,
  localparam int unsigned PG_W = BA_W - OFF_W,
  localparam int unsigned RA_W = PG_W + LANE_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_byte,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            map_enable,
  input  logic            xl_req,
  input  logic [BA_W-1:0] xl_addr,
  output logic            xl_valid,
  output logic [PA_W-1:0] xl_paddr
);
  logic [PA_W-1:0] rd_entry;
  logic [PA_W-1:0] xl_entry;
  wr_size_e        wr_size;

  assign wr_size = reg_byte ? WR_BYTE : WR_WORD;

  pgmap_bank #(.PA_W(PA_W), .IDX_W(PG_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_size  (wr_size),
    .wr_idx   (reg_addr[RA_W-1:LANE_BITS]),
    .wr_lane  (reg_addr[LANE_BITS-1:0]),
    .wr_data  (reg_wdata),
    .rd_idx   (reg_addr[RA_W-1:LANE_BITS]),
    .rd_entry (rd_entry),
    .xl_idx   (xl_addr[BA_W-1:OFF_W]),
    .xl_entry (xl_entry)
  );

  always_comb begin
    if (reg_addr[1]) begin
      reg_rdata = 16'(rd_entry[PA_W-1:16]);
    end else begin
      reg_rdata = rd_entry[15:0] & 16'hFFFE;
    end
  end

  pgmap_xlate #(.BA_W(BA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_xlate (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (xl_req),
    .map_on (map_enable),
    .ba     (xl_addr),
    .entry  (xl_entry),
    .valid  (xl_valid),
    .paddr  (xl_paddr)
  );
endmodule

// File: rtl/pgmap_checker.sv
module pgmap_checker #(
  parameter int unsigned BA_W  = 18,
  parameter int unsigned PA_W  = 22,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned RA_W  = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [RA_W-1:0] reg_addr,
  input logic [15:0]     reg_rdata,
  input logic            map_enable,
  input logic            xl_req,
  input logic [BA_W-1:0] xl_addr,
  input logic            xl_valid,
  input logic [PA_W-1:0] xl_paddr
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid); // R7

  AST_VALID_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> !xl_valid); // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> $stable(xl_paddr)); // R10

  AST_IO_PAGE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && map_enable && (xl_addr[BA_W-1:OFF_W] == '1))
      |=> (xl_paddr[PA_W-1:OFF_W] == '1)); // R8

  AST_UNMAPPED_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !map_enable) |=> (xl_paddr[PA_W-1:BA_W] == '0)); // R9

  AST_HIGH_WORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[1] |-> (reg_rdata[15:PA_W-16] == '0)); // R3

  AST_LOW_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr[1] |-> !reg_rdata[0]); // R2
endmodule

bind bus_page_map pgmap_checker #(
  .BA_W(BA_W), .PA_W(PA_W), .OFF_W(OFF_W), .RA_W(RA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .map_enable (map_enable),
  .xl_req     (xl_req),
  .xl_addr    (xl_addr),
  .xl_valid   (xl_valid),
  .xl_paddr   (xl_paddr)
);

// File: tb/tb_bus_page_map.sv
module tb_bus_page_map;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_byte;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        map_enable;
  logic        xl_req;
  logic [17:0] xl_addr;
  logic        xl_valid;
  logic [21:0] xl_paddr;

  int n_cmp;
  int n_bad;
  logic [21:0] model [32];

  bus_page_map dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_byte(reg_byte),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .map_enable(map_enable), .xl_req(xl_req), .xl_addr(xl_addr),
    .xl_valid(xl_valid), .xl_paddr(xl_paddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [6:0] a);
    logic [21:0] e;
    e = model[a[6:2]];
    return a[1] ? {10'd0, e[21:16]} : e[15:0];
  endfunction

  function automatic logic [21:0] exp_xlate(input logic en, input logic [17:0] ba);
    if (!en) return {4'd0, ba};
    if (ba[17:13] == 5'd31) return 22'h3FE000 + {9'd0, ba[12:0]};
    return model[ba[17:13]] + {9'd0, ba[12:0]};
  endfunction

  task automatic model_write(input logic bw, input logic [6:0] a, input logic [15:0] d);
    logic [21:0] e;
    e = model[a[6:2]];
    if (bw) begin
      case (a[1:0])
        2'd0: e[7:0]   = d[7:0];
        2'd1: e[15:8]  = d[7:0];
        2'd2: e[21:16] = d[5:0];
        default: ;
      endcase
    end else if (a[1]) begin
      e[21:16] = d[5:0];
    end else begin
      e[15:0] = d;
    end
    e[0] = 1'b0;
    model[a[6:2]] = e;
  endtask

  task automatic do_write(input logic bw, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_byte = bw; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(bw, a, d);
  endtask

  task automatic do_read(input string tag, input logic [6:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, 32'(reg_rdata), 32'(exp_read(a)));
  endtask

  task automatic do_xlate(input string tag, input logic en, input logic [17:0] ba);
    @(negedge clk);
    xl_req = 1'b1; map_enable = en; xl_addr = ba;
    @(negedge clk);
    xl_req = 1'b0;
    check({tag, " valid"}, 32'(xl_valid), 32'd1);
    check(tag, 32'(xl_paddr), 32'(exp_xlate(en, ba)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [21:0] held;
    n_cmp = 0; n_bad = 0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_byte = 1'b0; reg_addr = '0;
    reg_wdata = '0; map_enable = 1'b1; xl_req = 1'b0; xl_addr = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 valid", 32'(xl_valid), 32'd0);
    check("R1 paddr", 32'(xl_paddr), 32'd0);
    for (int i = 0; i < 128; i += 2) do_read("R1 entry", 7'(i));

    // R2 bit 0 cleared, R3 high-word format
    do_write(1'b0, {5'd3, 2'b00}, 16'hFFFF);
    do_read("R2 low word even", {5'd3, 2'b00});
    do_read("R3 addr bit0 ignored", {5'd3, 2'b01});
    do_write(1'b0, {5'd3, 2'b10}, 16'hFFFF);
    do_read("R3 high word", {5'd3, 2'b10});
    do_read("R4 low kept", {5'd3, 2'b00});

    // R5 byte lanes, lane 3 no effect
    do_write(1'b0, {5'd4, 2'b00}, 16'h1234);
    do_write(1'b0, {5'd4, 2'b10}, 16'h0015);
    do_write(1'b1, {5'd4, 2'b11}, 16'h00FF);
    do_read("R5 lane3 low", {5'd4, 2'b00});
    do_read("R5 lane3 high", {5'd4, 2'b10});
    do_write(1'b1, {5'd4, 2'b01}, 16'h00AB);
    do_read("R5 lane1", {5'd4, 2'b00});
    do_write(1'b1, {5'd4, 2'b10}, 16'hFFEE);
    do_read("R5 lane2", {5'd4, 2'b10});
    do_write(1'b1, {5'd4, 2'b00}, 16'hFF77);
    do_read("R5 lane0", {5'd4, 2'b00});

    // R6 neighbour untouched
    do_read("R6 neighbour", {5'd5, 2'b00});
    do_read("R6 neighbour", {5'd2, 2'b10});

    // R7 mapped and wrap
    do_xlate("R7 mapped", 1'b1, {5'd4, 13'h0123});
    do_write(1'b0, {5'd6, 2'b00}, 16'hFFFE);
    do_write(1'b0, {5'd6, 2'b10}, 16'h003F);
    do_xlate("R7 wrap", 1'b1, {5'd6, 13'h1FFF});

    // R8 I/O page bypass with nonzero entry 31
    do_write(1'b0, {5'd31, 2'b00}, 16'h4000);
    do_write(1'b0, {5'd31, 2'b10}, 16'h0001);
    do_xlate("R8 io page", 1'b1, {5'd31, 13'h0ABC});
    do_xlate("R8 io page top", 1'b1, 18'h3FFFF);

    // R9 unmapped
    do_xlate("R9 passthru", 1'b0, {5'd4, 13'h0042});

    // R10 hold and single-cycle valid
    held = xl_paddr;
    repeat (3) @(negedge clk);
    check("R10 valid low", 32'(xl_valid), 32'd0);
    check("R10 held", 32'(xl_paddr), 32'(held));

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        do_write(1'($urandom), 7'($urandom), 16'($urandom));
      end else if (op == 1) begin
        do_read("R3 R6 random read", 7'($urandom));
      end else begin
        do_xlate("R7 R8 R9 random xlate", ($urandom % 5) != 0, 18'($urandom));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule